// File: doc/BRIEF.md
# Edge Capture Channel with Two-Deep Timestamp Stack

This block timestamps transitions on an external input. The pin is first brought into the clock domain. Its edges are then qualified against a programmable edge mode. On each qualifying edge the block copies the current value of one of two internal free-running timers into a two-entry stack. Each timer has its own power-of-two prescale.

The block reports how full the stack is through a 2-bit status code. That code includes a saturating lost-data state for the case where captures arrive faster than software drains them. A running count of qualifying edges is kept. A one-cycle interrupt pulse can be enabled for each capture.

Software pulls results through a read strobe. The oldest held timestamp is always presented on the data output, and asserting the strobe removes it.

Top module: `edge_capture_unit`

## Requirements
- R1: Edge mode encoding is 2'b00 = no capture, 2'b01 = rising edges, 2'b10 = falling edges, 2'b11 = both edges; a transition that does not match the mode changes neither the stack, the status nor the edge count.
- R2: The pin passes through a two-flop synchroniser; with the pin changed before clock edge k, the capture takes effect at edge k+2 (status, count and irq visible after that edge).
- R3: The stored value is the timer value present just before the capturing edge, taken from timer A when the timer select is 0 and timer B when it is 1.
- R4: Status is 2'b00 with no entries, 2'b01 with one entry in the top slot, and 2'b10 with both slots occupied.
- R5: A capture while both slots are full discards the top entry, moves the bottom entry to the top, stores the new value at the bottom, and sets status to 2'b11.
- R6: rd_data always shows the top entry; a read strobe pops it so that the former bottom becomes the top; status 2'b11 goes to 2'b01 after one read and to 2'b00 after a second; a read while empty has no effect.
- R7: A read and a capture in the same cycle pop first and then push, so no lost-data status results from that pair.
- R8: Each timer advances by one every 2^p clock cycles, where p (0..7) is its prescale select.
- R9: The edge counter increments by exactly one for each qualifying edge and holds otherwise.
- R10: With the interrupt enable set, irq pulses high for exactly one cycle per capture; with it clear, irq stays low.
- R11: After reset the status is 2'b00, the edge count and both timers are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 1 | Asynchronous capture input |
| cfg_edge | input | 2 | Edge mode select |
| cfg_tsel | input | 1 | Timer select: 0 = timer A, 1 = timer B |
| cfg_presc_a | input | 3 | Prescale select of timer A |
| cfg_presc_b | input | 3 | Prescale select of timer B |
| cfg_irq_en | input | 1 | Capture interrupt enable |
| rd_en | input | 1 | Pop strobe for the stack |
| rd_data | output | 16 | Top stack entry |
| status | output | 2 | Stack fill / lost-data code |
| edge_count | output | 16 | Qualifying edge counter |
| irq | output | 1 | Capture interrupt pulse |
| timer_a | output | 16 | Current value of timer A |
| timer_b | output | 16 | Current value of timer B |

## Verification
A wrong fill state in the stack shows on the status port right after the clock edge that applies the faulty push or pop. It also shows on rd_data at the next read, because a misplaced entry returns a timestamp out of order. Errors in the synchroniser or the edge qualifier move or suppress the status, count and irq change away from the third edge after the pin moves, so they appear within three cycles. A prescale fault shows as a wrong timer step count over a window that is a whole multiple of the division period.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_t;

  typedef enum logic [1:0] {
    STK_EMPTY = 2'b00,
    STK_ONE   = 2'b01,
    STK_TWO   = 2'b10,
    STK_LOST  = 2'b11
  } stk_stat_t;

  // Decide whether a detected transition is one the mode asks for.
  function automatic logic edge_hit(edge_mode_t m, logic rise, logic fall);
    case (m)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  // Stack status after one cycle; a pop on an empty stack is ignored,
  // and a simultaneous pop is applied before the push.
  function automatic stk_stat_t next_status(stk_stat_t s, logic push, logic pop);
    logic pop_eff;
    pop_eff = pop && (s != STK_EMPTY);
    if (push && pop_eff)
      next_status = (s == STK_ONE) ? STK_ONE : STK_TWO;
    else if (push)
      next_status = (s == STK_EMPTY) ? STK_ONE :
                    (s == STK_ONE)   ? STK_TWO : STK_LOST;
    else if (pop_eff)
      next_status = (s == STK_ONE) ? STK_EMPTY : STK_ONE;
    else
      next_status = s;
  endfunction

endpackage

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int TW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] presc,
  output logic [TW-1:0] value
);
  localparam int DIVW = (1 << PW) - 1;

  logic [DIVW-1:0] div_cnt;
  logic            tick;

  // One tick whenever the low 'sel' bits of the divider are all ones.
  function automatic logic presc_tick(logic [DIVW-1:0] cnt, logic [PW-1:0] sel);
    logic [DIVW-1:0] mask;
    mask = (DIVW'(1) << sel) - DIVW'(1);
    return (cnt & mask) == mask;
  endfunction

  assign tick = presc_tick(div_cnt, presc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      value   <= '0;
    end else begin
      div_cnt <= div_cnt + DIVW'(1);
      if (tick) value <= value + TW'(1);
    end
  end
endmodule

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [SYNC:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC-1:0], pin};
  end

  // chain[SYNC-1] is the synchronised level, chain[SYNC] its previous value.
  assign rise =  chain[SYNC-1] & ~chain[SYNC];
  assign fall = ~chain[SYNC-1] &  chain[SYNC];
endmodule

// File: rtl/cap_stack.sv
module cap_stack
  import cap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_val,
  input  logic          pop,
  output logic [TW-1:0] top_val,
  output stk_stat_t     stat
);
  logic [TW-1:0] top_q, bot_q;
  logic          pop_eff;

  assign pop_eff = pop && (stat != STK_EMPTY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '0;
      bot_q <= '0;
      stat  <= STK_EMPTY;
    end else begin
      stat <= next_status(stat, push, pop);
      if (push && pop_eff) begin
        if (stat == STK_ONE) top_q <= push_val;
        else begin
          top_q <= bot_q;
          bot_q <= push_val;
        end
      end else if (push) begin
        case (stat)
          STK_EMPTY: top_q <= push_val;
          STK_ONE:   bot_q <= push_val;
          default: begin
            top_q <= bot_q;
            bot_q <= push_val;
          end
        endcase
      end else if (pop_eff && stat != STK_ONE) begin
        top_q <= bot_q;
      end
    end
  end

  assign top_val = top_q;
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int TW   = 16,
  parameter int PW   = 3,
  parameter int CW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_pin,
  input  logic [1:0]    cfg_edge,
  input  logic          cfg_tsel,
  input  logic [PW-1:0] cfg_presc_a,
  input  logic [PW-1:0] cfg_presc_b,
  input  logic          cfg_irq_en,
  input  logic          rd_en,
  output logic [TW-1:0] rd_data,
  output logic [1:0]    status,
  output logic [CW-1:0] edge_count,
  output logic          irq,
  output logic [TW-1:0] timer_a,
  output logic [TW-1:0] timer_b
);
  localparam int NTIMER = 2;

  logic [NTIMER-1:0][PW-1:0] presc_arr;
  logic [NTIMER-1:0][TW-1:0] tval;
  logic                      rise, fall;
  logic                      cap_evt;
  logic [TW-1:0]             cap_val;
  stk_stat_t                 stat;
  logic                      irq_q;
  logic [CW-1:0]             cnt_q;

  assign presc_arr[0] = cfg_presc_a;
  assign presc_arr[1] = cfg_presc_b;

  for (genvar g = 0; g < NTIMER; g++) begin : g_tmr
    cap_timer #(.TW(TW), .PW(PW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .presc (presc_arr[g]),
      .value (tval[g])
    );
  end

  cap_edge_sync #(.SYNC(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (cap_pin),
    .rise  (rise),
    .fall  (fall)
  );

  assign cap_evt = edge_hit(edge_mode_t'(cfg_edge), rise, fall);
  assign cap_val = tval[cfg_tsel];

  cap_stack #(.TW(TW)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (cap_evt),
    .push_val (cap_val),
    .pop      (rd_en),
    .top_val  (rd_data),
    .stat     (stat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cap_evt) cnt_q <= cnt_q + CW'(1);
      irq_q <= cap_evt & cfg_irq_en;
    end
  end

  assign status     = stat;
  assign edge_count = cnt_q;
  assign irq        = irq_q;
  assign timer_a    = tval[0];
  assign timer_b    = tval[1];
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    status,
  input logic          cap_evt,
  input logic          rd_en,
  input logic          irq,
  input logic          cfg_irq_en,
  input logic [CW-1:0] edge_count
);
  assert_lost_from_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b11) |-> ($past(status) == 2'b10 || $past(status) == 2'b11));

  assert_full_capture_overruns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b10 && cap_evt && !rd_en) |=> (status == 2'b11));

  assert_read_with_capture_no_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b00 && cap_evt && rd_en) |=> (status != 2'b11));

  assert_pop_single_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01 && rd_en && !cap_evt) |=> (status == 2'b00));

  assert_lost_read_to_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b11 && rd_en && !cap_evt) |=> (status == 2'b01));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (edge_count == $past(edge_count) + CW'(1)));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(edge_count));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cap_evt && cfg_irq_en));
endmodule

bind edge_capture_unit cap_checker #(.CW(CW)) u_cap_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .status     (status),
  .cap_evt    (cap_evt),
  .rd_en      (rd_en),
  .irq        (irq),
  .cfg_irq_en (cfg_irq_en),
  .edge_count (edge_count)
);

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0;
  logic [1:0]  cfg_edge = 2'b01;
  logic        cfg_tsel = 1'b0;
  logic [2:0]  cfg_presc_a = 3'd0;
  logic [2:0]  cfg_presc_b = 3'd0;
  logic        cfg_irq_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data, timer_a, timer_b, edge_count;
  logic [1:0]  status;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // scoreboard model
  logic [15:0] exp_q[$];
  bit          exp_lost = 0;
  logic [15:0] exp_cnt  = 0;
  logic        pin_lvl  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .cfg_edge(cfg_edge),
    .cfg_tsel(cfg_tsel), .cfg_presc_a(cfg_presc_a), .cfg_presc_b(cfg_presc_b),
    .cfg_irq_en(cfg_irq_en), .rd_en(rd_en), .rd_data(rd_data), .status(status),
    .edge_count(edge_count), .irq(irq), .timer_a(timer_a), .timer_b(timer_b)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_status();
    if (exp_q.size() == 0) return 2'b00;
    if (exp_q.size() == 1) return 2'b01;
    return exp_lost ? 2'b11 : 2'b10;
  endfunction

  function automatic bit qualifies(logic [1:0] mode, logic from, logic to);
    if (from == to) return 0;
    if (mode == 2'b01) return to;
    if (mode == 2'b10) return !to;
    if (mode == 2'b11) return 1;
    return 0;
  endfunction

  // Driver: moves the pin, predicts the capture, optionally reads in the capture cycle.
  task automatic drive_edge(input logic lvl, input bit with_read, input string req);
    bit          hit;
    logic [15:0] ts;
    @(negedge clk);
    cap_pin = lvl;
    @(posedge clk); @(posedge clk); @(negedge clk);
    hit = qualifies(cfg_edge, pin_lvl, lvl);
    pin_lvl = lvl;
    ts = cfg_tsel ? timer_b : timer_a;          // R3: value just before capture edge
    if (with_read && exp_q.size() > 0) begin
      check("R6 top before joint read", rd_data, exp_q[0]);
      rd_en = 1'b1;
    end
    // one edge before the capture edge nothing may have changed yet (R2)
    check({req, " R2 no early update"}, status, model_status());
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    if (with_read && exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      exp_lost = 0;
    end
    if (hit) begin
      if (exp_q.size() == 2) begin
        void'(exp_q.pop_front());
        exp_lost = 1;
      end
      exp_q.push_back(ts);
      exp_cnt++;
    end
    check({req, " status"}, status, model_status());
    check({req, " R9 count"}, edge_count, exp_cnt);
    check({req, " R10 irq"}, irq, hit && cfg_irq_en);
    @(posedge clk); @(negedge clk);
    check({req, " R10 single pulse"}, irq, 1'b0);
  endtask

  // Monitor side: pops the expected item and compares with the design's top entry.
  task automatic read_top(input string req);
    @(negedge clk);
    if (exp_q.size() > 0) check({req, " data"}, rd_data, exp_q[0]);
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    if (exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      exp_lost = 0;
    end
    check({req, " status"}, status, model_status());
  endtask

  initial begin
    logic [15:0] a0, b0;
    repeat (3) @(negedge clk);
    check("R11 status", status, 2'b00);
    check("R11 count", edge_count, 16'd0);
    check("R11 irq", irq, 1'b0);
    check("R11 timers", {timer_a, timer_b}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // R8 prescale
    cfg_presc_a = 3'd0; cfg_presc_b = 3'd3;
    @(negedge clk); a0 = timer_a; b0 = timer_b;
    repeat (64) @(negedge clk);
    check("R8 div1", timer_a - a0, 16'd64);
    check("R8 div8", timer_b - b0, 16'd8);
    cfg_presc_b = 3'd7;
    @(negedge clk); b0 = timer_b;
    repeat (256) @(negedge clk);
    check("R8 div128", timer_b - b0, 16'd2);
    cfg_presc_b = 3'd1;

    // Rising mode, timer A, irq enabled
    cfg_edge = 2'b01; cfg_tsel = 1'b0; cfg_irq_en = 1'b1;
    drive_edge(1'b1, 0, "R1 rise capture R4");
    drive_edge(1'b0, 0, "R1 fall ignored");
    drive_edge(1'b1, 0, "R4 second entry");
    repeat (5) @(negedge clk);
    drive_edge(1'b0, 0, "R1 fall ignored");
    drive_edge(1'b1, 0, "R5 overrun");
    read_top("R6 read lost");
    read_top("R6 read last");
    read_top("R6 read empty");
    check("R6 empty read count", edge_count, exp_cnt);

    // Falling mode, timer B, irq disabled
    cfg_edge = 2'b10; cfg_tsel = 1'b1; cfg_irq_en = 1'b0;
    drive_edge(1'b0, 0, "R3 fall timer B");
    drive_edge(1'b1, 0, "R1 rise ignored");
    drive_edge(1'b0, 0, "R10 no irq");

    // Both edges, with joint read and capture
    cfg_edge = 2'b11; cfg_tsel = 1'b0; cfg_irq_en = 1'b1;
    drive_edge(1'b1, 1, "R7 joint at two");
    drive_edge(1'b0, 0, "R5 both overrun");
    drive_edge(1'b1, 1, "R7 joint at lost");
    read_top("R6 drain1");
    drive_edge(1'b0, 1, "R7 joint at one");
    read_top("R6 drain2");

    // Disabled mode
    cfg_edge = 2'b00;
    drive_edge(1'b1, 0, "R1 none rise");
    drive_edge(1'b0, 0, "R1 none fall");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule